// File: doc/BRIEF.md
# BCD Seven-Segment Hold Decoder

This block turns a four-bit binary-coded decimal digit into the seven lines that drive one display digit. A capture control decides whether the stored digit follows the incoming code or keeps the last code it took. A blank control switches the whole digit off. A polarity control inverts every line. One instance can therefore drive a display whose segments light on a high level (common cathode) or on a low level (common anode). It can also drive a liquid-crystal digit: the polarity input receives the same square wave as the display backplane, so lit segments swing opposite to the backplane and dark segments swing with it.

The store is a synchronous register. On each rising clock edge it takes the input code while the capture control is high, and a synchronous reset clears it to zero. The segment lines are combinational from the stored code and from the blank and polarity inputs. The block checks for illegal codes and applies blanking first, and applies inversion last.

Top module: `seg7_hold_decoder`

## Requirements
- R1: A synchronous reset clears the stored digit to 0. With blank and polarity low, seg_out then reads 7'h3F.
- R2: On a rising edge where cap_en is 1, digit_in is stored. From that edge on, seg_out shows the new digit.
- R3: On a rising edge where cap_en is 0, the stored digit keeps its value, and changes on digit_in do not reach seg_out.
- R4: digit_in is 8421 BCD with bit 3 as the most significant bit. seg_out bits 0..6 are segments a..g (a top, b upper right, c lower right, d bottom, e lower left, f upper left, g middle). With blank and polarity low, the codes 0..9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R5: Stored codes 10 to 15 give a dark digit: seg_out is 0 with polarity low.
- R6: blank_in = 1 makes all segments inactive, whatever the stored or incoming code.
- R7: polarity_in = 1 inverts every line of the result, blanked digits included, so a blanked digit reads 7'h7F.
- R8: A change on blank_in or polarity_in reaches seg_out within the same clock cycle, with no clock edge in between.
- R9: blank_in does not disturb the stored digit. When blank drops, the digit captured earlier appears again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit_in | input | 4 | BCD code, bit 3 most significant |
| cap_en | input | 1 | 1: store follows digit_in on each edge; 0: hold |
| blank_in | input | 1 | 1: all segments inactive |
| polarity_in | input | 1 | 1: invert all segment lines |
| seg_out | output | 7 | Segment lines, bit 0 = a through bit 6 = g |

## Verification
The bench sweeps all sixteen codes. This catches a decoder that lights a fragment for codes 10 to 15, and a table entry with one wrong segment, such as a 6 or a 9 without its tail. It changes digit_in while the store holds, which exposes a store that ignores the capture control. It toggles blank and polarity in the middle of a cycle, which exposes a design that registers them or inverts before blanking; such a design would show a blank digit as all zeros under inversion. Random vectors mix all controls so that a blank that corrupts the stored code also shows up.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_N  = 7;
    localparam int LAST_LEGAL = 9;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_N-1:0]  seg_t;

    // Active-high glyph for a legal code, bit 0 = a ... bit 6 = g.
    function automatic seg_t glyph_of(input code_t c);
        seg_t g;
        unique case (c)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/seg7_digit_store.sv
module seg7_digit_store
    import seg7_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t code_d,
    output code_t code_q
);
    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (load)
            code_q <= code_d;
    end
endmodule

// File: rtl/seg7_glyph_decode.sv
module seg7_glyph_decode
    import seg7_pkg::*;
(
    input  code_t code,
    output seg_t  glyph,
    output logic  legal
);
    always_comb begin
        legal = (int'(code) <= LAST_LEGAL);
        glyph = legal ? glyph_of(code) : '0;
    end
endmodule

// File: rtl/seg7_drive_stage.sv
module seg7_drive_stage
    import seg7_pkg::*;
(
    input  seg_t glyph,
    input  logic legal,
    input  logic blank,
    input  logic invert,
    output seg_t lines
);
    logic show;
    assign show = legal & ~blank;

    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        // blanking first, then polarity
        assign lines[s] = (glyph[s] & show) ^ invert;
    end
endmodule

// File: rtl/seg7_hold_decoder.sv
module seg7_hold_decoder
    import seg7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] digit_in,
    input  logic              cap_en,
    input  logic              blank_in,
    input  logic              polarity_in,
    output logic [SEG_N-1:0]  seg_out
);
    code_t held;
    seg_t  glyph;
    logic  legal;

    seg7_digit_store u_store (
        .clk    (clk),
        .rst    (rst),
        .load   (cap_en),
        .code_d (digit_in),
        .code_q (held)
    );

    seg7_glyph_decode u_decode (
        .code  (held),
        .glyph (glyph),
        .legal (legal)
    );

    seg7_drive_stage u_drive (
        .glyph  (glyph),
        .legal  (legal),
        .blank  (blank_in),
        .invert (polarity_in),
        .lines  (seg_out)
    );
endmodule

// File: rtl/seg7_hold_decoder_chk.sv
module seg7_hold_decoder_chk
    import seg7_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] digit_in,
    input logic              cap_en,
    input logic              blank_in,
    input logic              polarity_in,
    input logic [SEG_N-1:0]  seg_out
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !blank_in && !polarity_in) |-> seg_out == 7'h3F);

    p_load_one_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cap_en) && $past(digit_in) == 4'd1
         && !blank_in && !polarity_in) |-> seg_out == 7'h06);

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cap_en) && $stable(blank_in) && $stable(polarity_in))
        |-> $stable(seg_out));

    p_illegal_dark_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cap_en) && $past(digit_in) > 4'd9
         && !blank_in && !polarity_in) |-> seg_out == '0);

    p_blank_dark_r6: assert property (@(posedge clk) disable iff (rst)
        (blank_in && !polarity_in) |-> seg_out == '0);

    p_blank_inverted_r7: assert property (@(posedge clk) disable iff (rst)
        (blank_in && polarity_in) |-> seg_out == '1);
endmodule

bind seg7_hold_decoder seg7_hold_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .digit_in    (digit_in),
    .cap_en      (cap_en),
    .blank_in    (blank_in),
    .polarity_in (polarity_in),
    .seg_out     (seg_out)
);

// File: tb/seg7_hold_decoder_bench.sv
`timescale 1ns/100ps
module seg7_hold_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] digit_in = '0;
    logic       cap_en = 1'b0;
    logic       blank_in = 1'b0;
    logic       polarity_in = 1'b0;
    logic [6:0] seg_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [3:0] model_q = '0;

    always #2 clk = ~clk;

    seg7_hold_decoder u_seg7_hold_decoder (
        .clk(clk), .rst(rst), .digit_in(digit_in), .cap_en(cap_en),
        .blank_in(blank_in), .polarity_in(polarity_in), .seg_out(seg_out)
    );

    function automatic logic [6:0] ref_glyph(input logic [3:0] c);
        case (c)
            4'd0: return 7'b0111111;
            4'd1: return 7'b0000110;
            4'd2: return 7'b1011011;
            4'd3: return 7'b1001111;
            4'd4: return 7'b1100110;
            4'd5: return 7'b1101101;
            4'd6: return 7'b1111101;
            4'd7: return 7'b0000111;
            4'd8: return 7'b1111111;
            4'd9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic logic [6:0] ref_lines(input logic [3:0] c, input logic b, input logic p);
        logic [6:0] v;
        v = b ? 7'b0 : ref_glyph(c);
        return p ? ~v : v;
    endfunction

    task automatic check(input string req);
        logic [6:0] exp;
        exp = ref_lines(model_q, blank_in, polarity_in);
        n_chk++;
        if (seg_out !== exp) begin
            n_bad++;
            $display("FAIL %s: seg_out=%h expected=%h (code %0d b=%0b p=%0b)",
                     req, seg_out, exp, model_q, blank_in, polarity_in);
        end
    endtask

    // drive at negedge, one edge, check 1 ns after the edge
    task automatic apply(input logic [3:0] d, input logic en, input logic b,
                         input logic p, input logic r, input string req);
        @(negedge clk);
        digit_in = d; cap_en = en; blank_in = b; polarity_in = p; rst = r;
        @(posedge clk);
        if (r) model_q = '0;
        else if (en) model_q = d;
        #1;
        check(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        // R1: reset clears store, even with capture asserted
        apply(4'd7, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        apply(4'd7, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R2/R4/R5: sweep all codes
        for (int c = 0; c < 16; c++)
            apply(c[3:0], 1'b1, 1'b0, 1'b0, 1'b0, c < 10 ? "R4" : "R5");
        for (int c = 0; c < 16; c++)
            apply(c[3:0], 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        // R3: hold while input wanders
        apply(4'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        for (int c = 0; c < 10; c++)
            apply(c[3:0], 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        // R6/R9: blank over a held digit, then release
        apply(4'd5, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        apply(4'd8, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        apply(4'd8, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        apply(4'd3, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        // R8: mid-cycle changes of blank and polarity
        for (int k = 0; k < 4; k++) begin
            apply(4'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
            blank_in = k[0]; polarity_in = k[1];
            #0.5; check("R8");
        end
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [3:0] d;
            logic [2:0] cb;
            d  = 4'($urandom);
            cb = 3'($urandom);
            apply(d, cb[0], cb[1] & cb[0], cb[2], ($urandom % 50) == 0, "R2");
            if (n % 7 == 0) begin
                polarity_in = ~polarity_in;
                #0.5; check("R8");
            end
        end
        finish_run();
    end
endmodule